// File: doc/BRIEF.md
# UART Receive Timeout and Break Logic

This block sits next to a UART receiver and its receive FIFO. It watches the FIFO fill level and two strobes from the receive path: the centre of each stop bit and each FIFO read. When data sits in the FIFO below the interrupt trigger level and no new character or read arrives for four character times, it raises a character-timeout interrupt. Software then drains the FIFO even though the trigger level was never reached.

On the same receive line the block detects a break. A break is the line held low for longer than one complete framed character. It reports each break as a single-clock pulse. On the transmit side it forces the serial output low for as long as the break-control bit is set.

Every time span is counted in 16x oversampling baud ticks. A character time follows the current frame configuration. Other logic must supply the receiver shift register, the FIFO storage and the baud generator.

Top module: `uart_rx_tmo_brk`

## Requirements
- R1: A character is 1 start bit + data bits + 1 parity bit when parity is on + 1 or 2 stop bits (`two_stop_i`=1 selects 2). `data_sel_i` encodes 0,1,2,3 as 5,6,7,8 data bits. One bit lasts 16 baud ticks.
- R2: While 0 < FIFO level < trigger level, `rx_tmo_irq_o` rises in the clock after the baud tick that completes 4 character times of ticks since the last restart. It then stays high until something clears it.
- R3: A `stop_mid_i` pulse restarts the timeout count and clears `rx_tmo_irq_o` in the next clock.
- R4: A `fifo_rd_i` pulse restarts the timeout count and clears `rx_tmo_irq_o` in the next clock.
- R5: While the FIFO level is 0, the count is held at zero and `rx_tmo_irq_o` is low from the next clock on.
- R6: While the FIFO level is greater than or equal to the trigger level, `rx_tmo_irq_o` is low from the next clock on. When the level drops below the trigger level without a restart, and the count has already reached 4 character times, the interrupt rises after the next baud tick.
- R7: `rx_i` passes through RX_SYNC flops (default 2). Once the synchronised line is low, `brk_det_o` pulses for one clock after the (character ticks + 1)th baud tick seen low.
- R8: Only one break pulse is produced per low period. Detection is re-armed only when the synchronised line has been high for at least one clock.
- R9: `tx_o` is 0 whenever `brk_ctl_i` is 1, and equals `tx_i` otherwise, with no clock delay.
- R10: During reset `rx_tmo_irq_o` and `brk_det_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | 16x oversampling tick, one clock wide |
| data_sel_i | input | 2 | Data bits select (0..3 = 5..8 bits) |
| parity_en_i | input | 1 | Parity bit present |
| two_stop_i | input | 1 | Two stop bits |
| rx_i | input | 1 | Serial receive line |
| stop_mid_i | input | 1 | Receiver strobe at the centre of a stop bit |
| fifo_rd_i | input | 1 | Receive FIFO read strobe |
| fifo_level_i | input | LVL_W | Receive FIFO fill level |
| trig_level_i | input | LVL_W | Receive interrupt trigger level |
| brk_ctl_i | input | 1 | Transmit break request |
| tx_i | input | 1 | Serial data from the transmitter |
| rx_tmo_irq_o | output | 1 | Character-timeout interrupt |
| brk_det_o | output | 1 | Break detected, one-clock pulse |
| tx_o | output | 1 | Serial transmit line |

## Verification
The timeout interrupt and the break pulse are registered, so each is due in the clock after the baud tick or strobe that causes it. The break path also lags a level change on `rx_i` by the synchroniser depth. `tx_o` follows `brk_ctl_i` and `tx_i` in the same clock. The bench changes inputs on the falling edge and holds each tick or strobe for exactly one rising edge. It samples the registered outputs at the next falling edge, which is the first point where the result is due. Before it counts ticks on the receive line, it waits three clocks after each `rx_i` change so that the synchroniser has settled.

// File: rtl/uart_tob_pkg.sv
package uart_tob_pkg;
  typedef struct packed {
    logic [1:0] data_sel;
    logic       par_en;
    logic       two_stop;
  } frame_cfg_t;

  localparam int unsigned MAX_CHAR_BITS = 12;
endpackage

// File: rtl/uart_char_len.sv
module uart_char_len
  import uart_tob_pkg::*;
#(
  parameter int unsigned OSR      = 16,
  parameter int unsigned TO_CHARS = 4,
  parameter int unsigned CT_W     = 8,
  parameter int unsigned TO_W     = 10
) (
  input  frame_cfg_t       cfg_i,
  output logic [CT_W-1:0]  char_ticks_o,
  output logic [TO_W-1:0]  to_ticks_o
);
  logic [3:0] bits;

  always_comb begin
    bits = 4'd6 + {2'b00, cfg_i.data_sel} + {3'b000, cfg_i.par_en}
         + (cfg_i.two_stop ? 4'd2 : 4'd1);
    char_ticks_o = CT_W'(bits) * CT_W'(OSR);
    to_ticks_o   = TO_W'(char_ticks_o) * TO_W'(TO_CHARS);
  end
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int unsigned LVL_W  = 7,
  parameter int unsigned TO_W   = 10,
  parameter int unsigned TO_MAX = 768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             stop_mid_i,
  input  logic             fifo_rd_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  input  logic [TO_W-1:0]  to_ticks_i,
  output logic             irq_o
);
  logic [TO_W-1:0] cnt_q;
  logic            irq_q;
  logic            empty, below, restart, due;

  assign empty   = (level_i == '0);
  assign below   = (level_i < trig_i);
  assign restart = stop_mid_i | fifo_rd_i;
  assign due     = tick_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, to_ticks_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart || empty) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q < to_ticks_i)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // interrupt holds until a restart, an empty FIFO or the trigger level drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else if (restart || empty || !below) begin
      irq_q <= 1'b0;
    end else if (due) begin
      irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  AST_TO_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(tick_i)); // R2
  AST_TO_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TO_W'(TO_MAX)); // R2
  AST_TO_STOP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_mid_i |=> (cnt_q == '0) && !irq_q); // R3
  AST_TO_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_i |=> (cnt_q == '0) && !irq_q); // R4
  AST_TO_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |=> !irq_q); // R5
  AST_TO_TRIG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i >= trig_i) |=> !irq_q); // R6
endmodule

// File: rtl/uart_brk_det.sv
module uart_brk_det #(
  parameter int unsigned CT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            rx_i,
  input  logic [CT_W-1:0] char_ticks_i,
  output logic            brk_o
);
  logic [CT_W-1:0] low_cnt_q;
  logic            armed_q;
  logic            brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      armed_q   <= 1'b1;
      brk_q     <= 1'b0;
    end else begin
      brk_q <= 1'b0;
      if (rx_i) begin
        low_cnt_q <= '0;
        armed_q   <= 1'b1;
      end else if (tick_i && armed_q) begin
        if (low_cnt_q >= char_ticks_i) begin
          brk_q   <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          low_cnt_q <= low_cnt_q + 1'b1;
        end
      end
    end
  end

  assign brk_o = brk_q;

  AST_BRK_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_q) |-> $past(!rx_i) && $past(tick_i)); // R7
  AST_BRK_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q |-> (low_cnt_q >= char_ticks_i)); // R7
  AST_BRK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q |=> !brk_q); // R8
  AST_BRK_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q |-> !armed_q); // R8
endmodule

// File: rtl/uart_rx_tmo_brk.sv
module uart_rx_tmo_brk
  import uart_tob_pkg::*;
#(
  parameter int unsigned LVL_W    = 7,
  parameter int unsigned OSR      = 16,
  parameter int unsigned TO_CHARS = 4,
  parameter int unsigned RX_SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             baud_tick_i,
  input  logic [1:0]       data_sel_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  input  logic             rx_i,
  input  logic             stop_mid_i,
  input  logic             fifo_rd_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [LVL_W-1:0] trig_level_i,
  input  logic             brk_ctl_i,
  input  logic             tx_i,
  output logic             rx_tmo_irq_o,
  output logic             brk_det_o,
  output logic             tx_o
);
  localparam int unsigned CT_MAX = MAX_CHAR_BITS * OSR;
  localparam int unsigned TO_MAX = CT_MAX * TO_CHARS;
  localparam int unsigned CT_W   = $clog2(CT_MAX + 1);
  localparam int unsigned TO_W   = $clog2(TO_MAX + 1);

  frame_cfg_t      cfg;
  logic [CT_W-1:0] char_ticks;
  logic [TO_W-1:0] to_ticks;
  logic            rx_s;

  assign cfg = '{data_sel: data_sel_i, par_en: parity_en_i, two_stop: two_stop_i};

  generate
    if (RX_SYNC == 0) begin : g_nosync
      assign rx_s = rx_i;
    end else if (RX_SYNC == 1) begin : g_sync1
      logic sq;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= 1'b1;
        else         sq <= rx_i;
      end
      assign rx_s = sq;
    end else begin : g_syncn
      logic [RX_SYNC-1:0] sq;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '1;
        else         sq <= {sq[RX_SYNC-2:0], rx_i};
      end
      assign rx_s = sq[RX_SYNC-1];
    end
  endgenerate

  uart_char_len #(
    .OSR(OSR), .TO_CHARS(TO_CHARS), .CT_W(CT_W), .TO_W(TO_W)
  ) u_len (
    .cfg_i        (cfg),
    .char_ticks_o (char_ticks),
    .to_ticks_o   (to_ticks)
  );

  uart_rx_timeout #(
    .LVL_W(LVL_W), .TO_W(TO_W), .TO_MAX(TO_MAX)
  ) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (baud_tick_i),
    .stop_mid_i (stop_mid_i),
    .fifo_rd_i  (fifo_rd_i),
    .level_i    (fifo_level_i),
    .trig_i     (trig_level_i),
    .to_ticks_i (to_ticks),
    .irq_o      (rx_tmo_irq_o)
  );

  uart_brk_det #(.CT_W(CT_W)) u_brk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (baud_tick_i),
    .rx_i         (rx_s),
    .char_ticks_i (char_ticks),
    .brk_o        (brk_det_o)
  );

  assign tx_o = brk_ctl_i ? 1'b0 : tx_i;
endmodule

// File: tb/uart_rx_tmo_brk_tb.sv
module uart_rx_tmo_brk_tb_top;
  localparam int LVL_W = 7;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             baud_tick = 1'b0;
  logic [1:0]       data_sel = 2'd3;
  logic             parity_en = 1'b0;
  logic             two_stop = 1'b0;
  logic             rx = 1'b1;
  logic             stop_mid = 1'b0;
  logic             fifo_rd = 1'b0;
  logic [LVL_W-1:0] level = '0;
  logic [LVL_W-1:0] trig = 7'd8;
  logic             brk_ctl = 1'b0;
  logic             tx_in = 1'b1;
  logic             irq, brk, tx_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int brk_seen;

  always #2 clk = ~clk; // 250 MHz

  uart_rx_tmo_brk #(.LVL_W(LVL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .baud_tick_i(baud_tick),
    .data_sel_i(data_sel), .parity_en_i(parity_en), .two_stop_i(two_stop),
    .rx_i(rx), .stop_mid_i(stop_mid), .fifo_rd_i(fifo_rd),
    .fifo_level_i(level), .trig_level_i(trig), .brk_ctl_i(brk_ctl),
    .tx_i(tx_in), .rx_tmo_irq_o(irq), .brk_det_o(brk), .tx_o(tx_out)
  );

  // vector: [7:6] data_sel, [5] parity, [4] two stop, [3:0] bits per character
  localparam logic [7:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 4'd7},
    {2'd3, 1'b0, 1'b0, 4'd10},
    {2'd3, 1'b1, 1'b1, 4'd12},
    {2'd1, 1'b1, 1'b0, 4'd9},
    {2'd2, 1'b0, 1'b1, 4'd10},
    {2'd0, 1'b1, 1'b1, 4'd9}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    if (brk === 1'b1) brk_seen++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_mid = 1'b1;
    @(negedge clk) stop_mid = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk) fifo_rd = 1'b1;
    @(negedge clk) fifo_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int ct;
    idle(3);
    chk("R10 irq in reset", irq, 1'b0);
    chk("R10 brk in reset", brk, 1'b0);
    @(negedge clk) rst_ni = 1'b1;
    idle(2);

    // table walk: timeout and break lengths per frame configuration (R1, R2, R4, R7, R8)
    for (int v = 0; v < 6; v++) begin
      {data_sel, parity_en, two_stop} = VEC[v][7:4];
      ct = int'(VEC[v][3:0]) * 16;
      rx = 1'b1; level = 7'd3; trig = 7'd8;
      pulse_stop();
      ticks(4 * ct - 1);
      chk("R1 R2 timeout not before 4 chars", irq, 1'b0);
      tick();
      chk("R1 R2 timeout at 4 chars", irq, 1'b1);
      pulse_rd();
      chk("R4 read clears timeout", irq, 1'b0);
      level = '0;
      @(negedge clk) rx = 1'b0;
      idle(3);
      brk_seen = 0;
      ticks(ct);
      chk("R1 R7 no break within one char", brk_seen != 0, 1'b0);
      tick();
      chk("R7 break pulse after char+1 ticks", brk, 1'b1);
      idle(1);
      chk("R8 break pulse one clock", brk, 1'b0);
      @(negedge clk) rx = 1'b1;
      idle(3);
    end

    // R3: stop-bit centre restarts mid-count, 7-bit characters
    {data_sel, parity_en, two_stop} = 4'b0000;
    ct = 7 * 16;
    level = 7'd2; trig = 7'd4;
    pulse_stop();
    ticks(200);
    pulse_stop();
    ticks(4 * ct - 1);
    chk("R3 restart delays timeout", irq, 1'b0);
    tick();
    chk("R3 timeout after restart", irq, 1'b1);
    pulse_stop();
    chk("R3 stop strobe clears timeout", irq, 1'b0);

    // R4: read restarts mid-count
    ticks(300);
    pulse_rd();
    ticks(4 * ct - 1);
    chk("R4 read delays timeout", irq, 1'b0);
    tick();
    chk("R4 timeout after read", irq, 1'b1);

    // R5: empty FIFO never times out, and clears a pending one
    @(negedge clk) level = '0;
    @(negedge clk);
    chk("R5 empty clears timeout", irq, 1'b0);
    ticks(4 * ct + 20);
    chk("R5 no timeout while empty", irq, 1'b0);
    level = 7'd2;
    ticks(4 * ct - 1);
    chk("R5 count held at zero while empty", irq, 1'b0);
    tick();
    chk("R5 timeout after data arrives", irq, 1'b1);

    // R6: at or above trigger suppresses
    level = 7'd4; trig = 7'd4;
    pulse_rd();
    ticks(4 * ct + 20);
    chk("R6 no timeout at trigger level", irq, 1'b0);
    level = 7'd3;
    tick();
    chk("R6 timeout once below trigger", irq, 1'b1);
    @(negedge clk) trig = 7'd3;
    @(negedge clk);
    chk("R6 reaching trigger clears timeout", irq, 1'b0);
    level = '0; trig = 7'd8;

    // R8: long low gives one pulse; one-clock high re-arms
    @(negedge clk) rx = 1'b0;
    idle(3);
    brk_seen = 0;
    ticks(ct + 1);
    chk("R7 break on long low", brk_seen == 1, 1'b1);
    brk_seen = 0;
    ticks(300);
    chk("R8 no second pulse in same low period", brk_seen != 0, 1'b0);
    @(negedge clk) rx = 1'b1;
    @(negedge clk) rx = 1'b0;
    idle(3);
    brk_seen = 0;
    ticks(ct);
    chk("R8 re-armed count restarts", brk_seen != 0, 1'b0);
    tick();
    chk("R8 pulse after re-arm", brk, 1'b1);
    @(negedge clk) rx = 1'b1;

    // R9: transmit break override
    @(negedge clk) begin tx_in = 1'b1; brk_ctl = 1'b0; end
    #1 chk("R9 tx follows data", tx_out, 1'b1);
    @(negedge clk) brk_ctl = 1'b1;
    #1 chk("R9 break forces tx low", tx_out, 1'b0);
    ticks(50);
    chk("R9 tx held low while bit set", tx_out, 1'b0);
    @(negedge clk) brk_ctl = 1'b0;
    #1 chk("R9 tx released", tx_out, 1'b1);
    @(negedge clk) tx_in = 1'b0;
    #1 chk("R9 tx follows low data", tx_out, 1'b0);

    idle(2);
    finish_run();
  end
endmodule